// File: doc/BRIEF.md
# External Bus Cycle Sequencer with Idle-State Insertion

This block drives an external memory bus that is split into eight chip-select areas. It takes one access request at a time: an address, a read or write flag, and the per-area timing settings. It then plays out the access states on the address, chip-select, read-strobe, write-strobe and data-drive outputs. The area is the top three bits of the address. Each area is set either to a two-state access or to a three-state access. A three-state access can be stretched by a programmed number of wait states, by the active-low wait input, or by both.

A device with a slow output turn-off can still hold the data bus when the next device starts to drive it. To prevent this, the sequencer can place one dead state in front of an access that follows another access with no gap. Two enable inputs control this. The first covers a read that follows a read to a different area. The second covers a write that follows a read. During the dead state every strobe and chip select is inactive.

A cycle counts as following with no gap only when its request is accepted in the last state of the previous access. If the bus has already sat idle for a state, the earlier cycle is forgotten and no dead state is added.

Top module: `ebus_idle_seq`

## Requirements
- R1: After reset, `req_ready` is 1, all `cs_n` bits are 1, `rd_n` and `wr_n` are 1, and `data_oe` and `done` are 0.
- R2: The area is `req_addr[23:21]`. During every access state only the chip select of that area is low (bit n of `cs_n` belongs to area n), and `bus_addr` carries the accepted address.
- R3: An area whose bit in `area_three_st` is 0 completes in two states. An area whose bit is 1 completes in three states when no wait applies.
- R4: A three-state area gets `area_waits[2n+1:2n]` wait states after its second state, before its third.
- R5: For an area whose bit in `area_pin_wait` is 1, `wait_n` is sampled at the end of the second state and of each wait state. A low value adds a further wait state. For other areas `wait_n` has no effect.
- R6: With `idle_rr_en` at 1, a read accepted during the final state of a read to a different area is preceded by exactly one state in which all `cs_n`, `rd_n` and `wr_n` are 1 and `data_oe` is 0.
- R7: A read that follows a read to the same area gets no idle state. Neither does any read-after-read when `idle_rr_en` is 0.
- R8: A write accepted during the final state of a read gets one idle state when `idle_wr_en` is 1, and none when it is 0.
- R9: An access that follows a write never gets an idle state.
- R10: A request accepted while the sequencer waits with no access in progress starts its first access state on the next clock, with no idle state.
- R11: `data_oe` is 1 in every access state of a write and at no other time. `rd_n` is low in every access state of a read. `wr_n` is low from the second access state of a write to its last.
- R12: `done` is 1 for exactly one clock, in the last access state. `req_ready` is 1 while waiting and during that last state. A request is taken when `req_valid` and `req_ready` are both 1 at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 24 | Request address; top three bits select the area |
| req_write | input | 1 | 1 = write, 0 = read |
| area_three_st | input | 8 | Per area: 1 = three-state access, 0 = two-state |
| area_waits | input | 16 | Per area: two-bit programmed wait count |
| area_pin_wait | input | 8 | Per area: 1 = honour `wait_n` |
| idle_rr_en | input | 1 | Enable idle state for read followed by read to another area |
| idle_wr_en | input | 1 | Enable idle state for read followed by write |
| wait_n | input | 1 | Active-low wait request from the device |
| req_ready | output | 1 | Sequencer can take a request this clock |
| bus_addr | output | 24 | External address |
| cs_n | output | 8 | Active-low chip selects, one per area |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| data_oe | output | 1 | Drive enable for the data bus |
| done | output | 1 | Last access state of the current cycle |

## Verification
A request taken at a rising edge shows its first access state in the next clock, or one clock later when an idle state is inserted. `done` then follows after two states, after three, or after three plus the wait states. The bench sets inputs and samples outputs at falling edges only. For each state from acceptance onward it compares the full strobe pattern against a timeline computed from the area settings. For back-to-back pairs it looks at the state right after `done` to decide whether an idle state was inserted. The wait input is released at a known sampled state, so the extra wait count is fixed in advance.

// File: rtl/ebus_idle_seq.sv
module ebus_idle_seq #(
  parameter int ADDR_W = 24,
  parameter int AREA_W = 3,
  parameter int WAIT_W = 2,
  localparam int AREAS = 1 << AREA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    req_write,
  input  logic [AREAS-1:0]        area_three_st,
  input  logic [AREAS*WAIT_W-1:0] area_waits,
  input  logic [AREAS-1:0]        area_pin_wait,
  input  logic                    idle_rr_en,
  input  logic                    idle_wr_en,
  input  logic                    wait_n,
  output logic                    req_ready,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [AREAS-1:0]        cs_n,
  output logic                    rd_n,
  output logic                    wr_n,
  output logic                    data_oe,
  output logic                    done
);
  typedef enum logic [2:0] {S_RDY, S_TI, S_T1, S_T2, S_TW, S_T3} st_t;
  st_t st, st_nx;

  logic [ADDR_W-1:0] cur_addr;
  logic [AREA_W-1:0] cur_area;
  logic              cur_write, cur_three, cur_pin;
  logic [WAIT_W-1:0] wcnt;

  logic [AREA_W-1:0] req_area;
  logic accept, hazard, wait_more, in_acc;

  assign req_area  = req_addr[ADDR_W-1 -: AREA_W];
  assign done      = (st == S_T3) || (st == S_T2 && !cur_three);
  assign req_ready = (st == S_RDY) || done;
  assign accept    = req_valid && req_ready;
  assign hazard    = done && !cur_write &&
                     ((req_write && idle_wr_en) ||
                      (!req_write && idle_rr_en && req_area != cur_area));
  assign wait_more = (wcnt != '0) || (cur_pin && !wait_n);
  assign in_acc    = (st == S_T1) || (st == S_T2) || (st == S_TW) || (st == S_T3);

  always_comb begin
    st_nx = st;
    unique case (st)
      S_RDY: if (accept) st_nx = S_T1;
      S_TI:  st_nx = S_T1;
      S_T1:  st_nx = S_T2;
      S_T2:
        if (cur_three) st_nx = wait_more ? S_TW : S_T3;
        else           st_nx = accept ? (hazard ? S_TI : S_T1) : S_RDY;
      S_TW:  if (!wait_more) st_nx = S_T3;
      S_T3:  st_nx = accept ? (hazard ? S_TI : S_T1) : S_RDY;
      default: st_nx = S_RDY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RDY;
      cur_addr  <= '0;
      cur_area  <= '0;
      cur_write <= 1'b0;
      cur_three <= 1'b0;
      cur_pin   <= 1'b0;
      wcnt      <= '0;
    end else begin
      st <= st_nx;
      if (accept) begin
        cur_addr  <= req_addr;
        cur_area  <= req_area;
        cur_write <= req_write;
        cur_three <= area_three_st[req_area];
        cur_pin   <= area_pin_wait[req_area];
        wcnt      <= area_waits[req_area*WAIT_W +: WAIT_W];
      end else if (((st == S_T2 && cur_three) || st == S_TW) && wcnt != '0) begin
        wcnt <= wcnt - 1'b1;
      end
    end
  end

  assign bus_addr = cur_addr;
  assign cs_n     = in_acc ? ~(AREAS'(1) << cur_area) : '1;
  assign rd_n     = !(in_acc && !cur_write);
  assign wr_n     = !(in_acc && st != S_T1 && cur_write);
  assign data_oe  = in_acc && cur_write;
endmodule

// File: rtl/ebus_idle_seq_chk.sv
module ebus_idle_seq_chk #(
  parameter int ADDR_W = 24,
  parameter int AREA_W = 3,
  localparam int AREAS = 1 << AREA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              idle_rr_en,
  input logic              idle_wr_en,
  input logic              req_ready,
  input logic [AREAS-1:0]  cs_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              data_oe,
  input logic              done
);
  logic [AREA_W-1:0] ra;
  assign ra = req_addr[ADDR_W-1 -: AREA_W];

  a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r11_oe_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (rd_n && !(&cs_n)));

  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done && req_valid && idle_rr_en && !rd_n && !req_write && cs_n[ra])
    |=> (&cs_n && rd_n && wr_n && !data_oe));

  a_r7_same_area: assert property (@(posedge clk) disable iff (!rst_n)
    (done && req_valid && !rd_n && !req_write && !cs_n[ra]) |=> !(&cs_n));

  a_r8_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (done && req_valid && idle_wr_en && !rd_n && req_write) |=> (&cs_n && wr_n));

  a_r9_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done && req_valid && data_oe) |=> !(&cs_n));

  a_r10_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !done) |=> !(&cs_n));
endmodule

bind ebus_idle_seq ebus_idle_seq_chk #(.ADDR_W(ADDR_W), .AREA_W(AREA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_write(req_write), .idle_rr_en(idle_rr_en), .idle_wr_en(idle_wr_en),
  .req_ready(req_ready), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
  .data_oe(data_oe), .done(done));

// File: tb/ebus_idle_seq_tb.sv
`timescale 1ns/1ps
module ebus_idle_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [7:0]  area_three_st = 8'b1101_1011;
  logic [15:0] area_waits = 16'h0008;
  logic [7:0]  area_pin_wait = 8'b0000_1000;
  logic        idle_rr_en = 1'b1;
  logic        idle_wr_en = 1'b1;
  logic        wait_n = 1'b1;
  logic        req_ready, rd_n, wr_n, data_oe, done;
  logic [23:0] bus_addr;
  logic [7:0]  cs_n;

  int checks = 0;
  int errs = 0;

  always #2.5 clk = ~clk;

  ebus_idle_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .area_three_st(area_three_st), .area_waits(area_waits),
    .area_pin_wait(area_pin_wait), .idle_rr_en(idle_rr_en), .idle_wr_en(idle_wr_en),
    .wait_n(wait_n), .req_ready(req_ready), .bus_addr(bus_addr), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .data_oe(data_oe), .done(done));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] ad(input logic [2:0] a);
    return {a, 21'h0_5A3C};
  endfunction

  // One access from the waiting state; rel = sampled state index after which wait_n goes high
  task automatic single(input logic [2:0] a, input bit w, input int len, input int rel, input string tag);
    logic [11:0] exp_v, act_v;
    @(negedge clk);
    chk(req_ready, {tag, " ready R12"}, req_ready, 1);
    req_valid = 1'b1; req_addr = ad(a); req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < len; i++) begin
      exp_v = {~(8'd1 << a), w, !(w && i >= 1), w, i == len - 1};
      act_v = {cs_n, rd_n, wr_n, data_oe, done};
      chk(act_v == exp_v, $sformatf("%s state%0d R2 R3 R11 R12", tag, i), act_v, exp_v);
      if (i == 0) chk(bus_addr == ad(a), {tag, " addr R2"}, bus_addr, ad(a));
      if (i == rel) wait_n = 1'b1;
      @(negedge clk);
    end
    act_v = {cs_n, rd_n, wr_n, data_oe, done};
    chk(act_v == 12'hFFC && req_ready, {tag, " back to wait R12"}, act_v, 12'hFFC);
  endtask

  // Second request held during first; accepted in first's last state
  task automatic pair(input logic [2:0] a1, input bit w1, input logic [2:0] a2, input bit w2,
                      input bit idle_exp, input string tag);
    int g;
    logic [10:0] act_v;
    @(negedge clk);
    req_valid = 1'b1; req_addr = ad(a1); req_write = w1;
    @(negedge clk);
    req_addr = ad(a2); req_write = w2;
    g = 0;
    while (!done && g < 20) begin @(negedge clk); g++; end
    @(negedge clk);
    req_valid = 1'b0;
    act_v = {cs_n, rd_n, wr_n, data_oe};
    if (idle_exp) begin
      chk(act_v == 11'h7FE, {tag, " idle state"}, act_v, 11'h7FE);
      @(negedge clk);
    end
    chk(cs_n == ~(8'd1 << a2), {tag, " second select"}, cs_n, ~(8'd1 << a2));
    g = 0;
    while (!done && g < 20) begin @(negedge clk); g++; end
    @(negedge clk);
  endtask

  task automatic gap(input string tag);
    int g;
    @(negedge clk);
    req_valid = 1'b1; req_addr = ad(3'd0); req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    g = 0;
    while (!done && g < 20) begin @(negedge clk); g++; end
    @(negedge clk);
    req_valid = 1'b1; req_addr = ad(3'd4); req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(cs_n == 8'hEF, {tag, " R10 no idle after gap"}, cs_n, 8'hEF);
    g = 0;
    while (!done && g < 20) begin @(negedge clk); g++; end
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    errs++; checks++;
    $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({req_ready, cs_n, rd_n, wr_n, data_oe, done} == 13'h1FFC, "R1 reset outputs",
        {req_ready, cs_n, rd_n, wr_n, data_oe, done}, 13'h1FFC);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && cs_n == 8'hFF, "R1 after reset", {req_ready, cs_n}, 9'h1FF);

    single(3'd2, 1'b0, 2, -1, "R3 two-state read");
    single(3'd0, 1'b0, 3, -1, "R3 three-state read");
    single(3'd7, 1'b1, 3, -1, "R11 write");
    single(3'd5, 1'b1, 2, -1, "R11 two-state write");
    single(3'd1, 1'b0, 5, -1, "R4 programmed waits");
    wait_n = 1'b0;
    single(3'd3, 1'b0, 5, 3, "R5 pin wait");
    wait_n = 1'b0;
    single(3'd0, 1'b0, 3, -1, "R5 pin wait ignored");
    wait_n = 1'b1;

    pair(3'd0, 1'b0, 3'd6, 1'b0, 1'b1, "R6 read-read other area");
    pair(3'd2, 1'b0, 3'd5, 1'b0, 1'b1, "R6 two-state read-read");
    pair(3'd6, 1'b0, 3'd6, 1'b0, 1'b0, "R7 same area");
    idle_rr_en = 1'b0;
    pair(3'd0, 1'b0, 3'd6, 1'b0, 1'b0, "R7 enable off");
    idle_rr_en = 1'b1;
    pair(3'd0, 1'b0, 3'd0, 1'b1, 1'b1, "R8 write after read");
    idle_wr_en = 1'b0;
    pair(3'd0, 1'b0, 3'd4, 1'b1, 1'b0, "R8 enable off");
    idle_wr_en = 1'b1;
    pair(3'd7, 1'b1, 3'd0, 1'b0, 1'b0, "R9 read after write");
    pair(3'd7, 1'b1, 3'd4, 1'b1, 1'b0, "R9 write after write");
    gap("gap");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule